// File: doc/BRIEF.md
# Programmable Program/Erase Pulse Timer

This block times one high-voltage pulse for a non-volatile memory program or erase step. A start strobe captures three codes: a prescale-select code, an exponent code and a multiplier code. The block then holds its active-high pulse output for R × 2^N × M system clock cycles. R comes from a decode of the prescale-select code, N is the exponent code plus a fixed offset, and M is the multiplier code plus one. When the count runs out, the output falls and a one-cycle done strobe marks the end.

A surrounding session controller sets the codes, pulses start and waits for done. To hold the block idle, keep its synchronous active-low reset asserted. Inside, the count is split into three cascaded stages: a prescaler, a power-of-two stage and a multiplier stage. No stage needs to hold the full product.

Top module: `ptmr_top`

## Requirements
- R1: While the synchronous reset is low, and in the cycle after any clock edge that samples it low, the pulse output and the done output are both 0. This holds even when a pulse was in progress.
- R2: A start sampled high at a clock edge while no pulse is running makes the pulse output 1 from that edge onward.
- R3: The pulse output stays 1 for exactly R × 2^N × M consecutive cycles. For example, prescale code 3'b101, exponent code 2'b00 and multiplier code 7'h07 give 1024 cycles.
- R4: Prescale-select code c (3 bits) gives R = c − 1 for c from 2 to 7, and R = 1 for codes 0 and 1. Code 3'b101 therefore gives R = 4.
- R5: The 2-bit exponent code e gives N = e + 5, so code 2'b00 gives 32 and code 2'b11 gives 256.
- R6: The 7-bit multiplier code m gives M = m + 1, so codes 7'h00 to 7'h7F give 1 to 128.
- R7: The codes are captured at the accepted start. Changing them while the pulse runs leaves the pulse length unchanged.
- R8: A start that arrives while a pulse is running is ignored. The pulse is neither restarted nor lengthened.
- R9: Done is 1 for exactly one cycle: the first cycle after the last pulse cycle. Done is never 1 while the pulse output is 1.
- R10: A start sampled in the cycle where done is 1 is accepted, and the next pulse begins with no idle gap beyond that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; held low while the timer is disabled |
| start | input | 1 | Start strobe for one pulse |
| rate_sel | input | 3 | Prescale-select code (R) |
| exp_sel | input | 2 | Exponent code (N = code + 5) |
| mult_sel | input | 7 | Multiplier code (M = code + 1) |
| hv_pulse | output | 1 | Active-high timed pulse |
| pulse_done | output | 1 | One-cycle strobe as the pulse ends |

## Verification
Some properties are checked on every cycle. A rising pulse must follow a sampled start. A running pulse is never cut short by a second start. The captured stage limits stay frozen while the pulse runs. Done lasts one cycle, never overlaps the pulse, and always follows one. Each stage counter stays within its captured limit.

Other properties depend on the actual count, so only the bench scenarios can show them. These are the exact length for each code decode, the immunity to code changes and stray starts during a pulse, back-to-back restart from the done cycle, and reset in the middle of a pulse.

// File: rtl/ptmr_pkg.sv
// Shared constants and decode helpers for the pulse timer.
// Assumes: the prescale decode is a pure function of the code value.
package ptmr_pkg;
    localparam int NUM_STAGES = 3;

    // Stage order in the cascade: prescaler first, multiplier last.
    typedef enum int {
        STG_PRESCALE = 0,
        STG_POWER    = 1,
        STG_MULT     = 2
    } stage_e;

    // Map a prescale-select code to its division ratio R.
    function automatic int unsigned ptmr_ratio(input int unsigned code);
        return (code < 2) ? 1 : code - 1;
    endfunction
endpackage

// File: rtl/ptmr_stage.sv
// One counting stage of the cascade. While run is high, every step
// advances the count from 0 to limit; the step that finds the count at
// limit raises wrap and returns the count to 0.
// Assumes: limit is stable while run is high.
module ptmr_stage #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt;

    // Terminal step of this stage.
    assign wrap = step && (cnt == limit);

    // Advance or clear the stage count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (step)
            cnt <= wrap ? '0 : cnt + 1'b1;
    end

    // R3: a stage never counts past its captured limit.
    assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= limit));
endmodule

// File: rtl/ptmr_ctrl.sv
// Pulse control: accepts a start when idle, captures the decoded stage
// limits, holds the pulse until the last stage wraps, then strobes done.
// Assumes: last is high only on the final counted cycle of a pulse.
module ptmr_ctrl
    import ptmr_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int EXP_W  = 2,
    parameter int MULT_W = 7,
    parameter int N_BASE = 5,
    parameter int CNT_W  = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    input  logic [SEL_W-1:0]                     rate_sel,
    input  logic [EXP_W-1:0]                     exp_sel,
    input  logic [MULT_W-1:0]                    mult_sel,
    input  logic                                 last,
    output logic                                 pulse,
    output logic                                 done,
    output logic [NUM_STAGES-1:0][CNT_W-1:0]     lims
);
    logic [NUM_STAGES-1:0][CNT_W-1:0] lims_next;

    // Decode the input codes into per-stage terminal counts.
    always_comb begin
        lims_next[STG_PRESCALE] = CNT_W'(ptmr_ratio(32'(rate_sel)) - 1);
        lims_next[STG_POWER]    = CNT_W'((64'd1 << (N_BASE + 32'(exp_sel))) - 64'd1);
        lims_next[STG_MULT]     = CNT_W'(mult_sel);
    end

    // Pulse state, captured limits and done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            done  <= 1'b0;
            lims  <= '0;
        end else begin
            done <= 1'b0;
            if (!pulse && start) begin
                pulse <= 1'b1;
                lims  <= lims_next;
            end else if (pulse && last) begin
                pulse <= 1'b0;
                done  <= 1'b1;
            end
        end
    end

    // R2: the pulse rises only after a sampled start.
    assert_rise_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(start));
    // R8: a running pulse continues until the final count, whatever start does.
    assert_no_retrigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !last) |=> pulse);
    // R7: captured limits are frozen while the pulse runs.
    assert_codes_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && $past(pulse)) |-> $stable(lims));
    // R9: done is a single-cycle strobe.
    assert_single_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: done never overlaps the pulse.
    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pulse && done));
    // R9: done directly follows a pulse cycle.
    assert_done_after_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(pulse));
endmodule

// File: rtl/ptmr_top.sv
// Programmable pulse timer top. The pulse lasts R * 2^N * M cycles,
// counted by a cascade of three stages that a generate loop builds.
// Assumes: rst_n is held low while the timer is disabled.
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int EXP_W  = 2,
    parameter int MULT_W = 7,
    parameter int N_BASE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SEL_W-1:0]  rate_sel,
    input  logic [EXP_W-1:0]  exp_sel,
    input  logic [MULT_W-1:0] mult_sel,
    output logic              hv_pulse,
    output logic              pulse_done
);
    localparam int N_MAX  = N_BASE + (1 << EXP_W) - 1;
    localparam int W_A    = (N_MAX > MULT_W) ? N_MAX : MULT_W;
    localparam int CNT_W  = (W_A > SEL_W) ? W_A : SEL_W;

    logic [NUM_STAGES-1:0][CNT_W-1:0] lims;
    logic                             stage_step [NUM_STAGES];
    logic                             stage_wrap [NUM_STAGES];
    logic                             pulse;

    ptmr_ctrl #(
        .SEL_W (SEL_W),
        .EXP_W (EXP_W),
        .MULT_W(MULT_W),
        .N_BASE(N_BASE),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .rate_sel(rate_sel),
        .exp_sel (exp_sel),
        .mult_sel(mult_sel),
        .last    (stage_wrap[NUM_STAGES-1]),
        .pulse   (pulse),
        .done    (pulse_done),
        .lims    (lims)
    );

    // Build the cascade: each stage steps on the wrap of the one before it.
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign stage_step[g] = pulse;
        end else begin : g_link
            assign stage_step[g] = stage_wrap[g-1];
        end
        ptmr_stage #(.CNT_W(CNT_W)) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (pulse),
            .step (stage_step[g]),
            .limit(lims[g]),
            .wrap (stage_wrap[g])
        );
    end

    assign hv_pulse = pulse;
endmodule

// File: tb/sim_ptmr_top.sv
module sim_ptmr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] rate_sel = '0;
    logic [1:0] exp_sel = '0;
    logic [6:0] mult_sel = '0;
    logic       hv_pulse, pulse_done;
    int         errors = 0;
    int         checks = 0;

    always #10 clk = ~clk;

    ptmr_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rate_sel(rate_sel), .exp_sel(exp_sel), .mult_sel(mult_sel),
        .hv_pulse(hv_pulse), .pulse_done(pulse_done)
    );

    // {rate code, exponent code, multiplier code, expected length}
    localparam logic [29:0] VEC [8] = '{
        {3'b101, 2'b00, 7'h07, 18'd1024},
        {3'b010, 2'b00, 7'h00, 18'd32},
        {3'b000, 2'b00, 7'h00, 18'd32},
        {3'b001, 2'b01, 7'h00, 18'd64},
        {3'b111, 2'b00, 7'h00, 18'd192},
        {3'b011, 2'b11, 7'h01, 18'd1024},
        {3'b110, 2'b10, 7'h02, 18'd1920},
        {3'b100, 2'b00, 7'h7F, 18'd12288}
    };

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Drive a start at a negedge; check the rise one edge later (R2).
    task automatic launch(input logic [2:0] s, input logic [1:0] e, input logic [6:0] m);
        start = 1'b1; rate_sel = s; exp_sel = e; mult_sel = m;
        @(negedge clk);
        start = 1'b0;
        chk(hv_pulse == 1'b1, "R2 pulse rises after start", int'(hv_pulse), 1);
    endtask

    // Count high cycles; optionally disturb codes and start (R7, R8).
    task automatic measure(input int expl, input bit disturb, input string tag);
        int cnt = 0;
        while (hv_pulse && cnt < 300000) begin
            cnt++;
            if (disturb && cnt == 3) begin
                rate_sel = 3'b111; exp_sel = 2'b11; mult_sel = 7'h7F;
            end
            start = disturb && (cnt == 5);
            @(negedge clk);
        end
        start = 1'b0;
        chk(cnt == expl, tag, cnt, expl);
        chk(pulse_done == 1'b1, "R9 done in first low cycle", int'(pulse_done), 1);
    endtask

    task automatic settle();
        @(negedge clk);
        chk(pulse_done == 1'b0 && hv_pulse == 1'b0, "R9 done lasts one cycle",
            int'({hv_pulse, pulse_done}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(hv_pulse == 1'b0 && pulse_done == 1'b0, "R1 idle in reset",
            int'({hv_pulse, pulse_done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hv_pulse == 1'b0, "R1 idle after reset", int'(hv_pulse), 0);

        // R3 R4 R5 R6: table of decodes and lengths
        for (int i = 0; i < 8; i++) begin
            launch(VEC[i][29:27], VEC[i][26:25], VEC[i][24:18]);
            measure(int'(VEC[i][17:0]), 1'b0, "R3 R4 R5 R6 pulse length");
            settle();
        end

        // R7 R8: code changes and a stray start during the pulse
        launch(3'b010, 2'b00, 7'h03);
        measure(128, 1'b1, "R7 R8 length unchanged by disturbance");
        settle();

        // R10: back-to-back start in the done cycle
        launch(3'b000, 2'b00, 7'h00);
        measure(32, 1'b0, "R3 first of back-to-back");
        launch(3'b001, 2'b00, 7'h01);
        measure(64, 1'b0, "R10 second of back-to-back");
        settle();

        // R1: reset in the middle of a pulse
        launch(3'b101, 2'b00, 7'h07);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(hv_pulse == 1'b0 && pulse_done == 1'b0, "R1 reset aborts pulse",
            int'({hv_pulse, pulse_done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(hv_pulse == 1'b0 && pulse_done == 1'b0, "R1 stays idle after abort",
            int'({hv_pulse, pulse_done}), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule